// File: doc/BRIEF.md
# Cascadable Eight-Line Interrupt Controller

This block collects eight interrupt request lines, ranks them by fixed priority and raises one interrupt output toward a processor. Software reaches it through a byte-wide port with a single address bit (`a0`) plus write and read strobes. After reset the block waits for a configuration sequence of three or four words on that port. Once configured, the same port carries mask writes, end-of-interrupt commands, mode changes and read-back selection. A one-cycle acknowledge pulse moves the winning request into service and returns an 8-bit vector on the read bus in the same cycle. The vector is the programmed base with the level in its low three bits.

Two instances can be chained. The role pin marks one instance as the primary. The primary's configuration names which of its lines carry a secondary. When the primary grants such a line it does not answer with a vector. It places the line number on a cascade bus instead, and the secondary whose configured identity matches answers the acknowledge. Software then clears the level in the secondary and the cascade line in the primary, each with its own specific end-of-interrupt.

The configuration sequencer uses these states:
- `ST_UNINIT`: after reset.
- `ST_GET_BASE`: entered from any state on a start word.
- `ST_GET_CASC`: after the base word, unless single mode is selected.
- `ST_GET_MODE`: after the cascade word, or after the base word in single mode, when the start word asked for a mode word.
- `ST_RUN`: once the last expected word has arrived.

In `ST_RUN`, `a0=1` writes load the mask. `a0=0` writes are decoded as commands.

Top module: `pic8_cascade`

## Requirements
- R1: An `a0=0` write with data bit 4 set starts configuration. It sets the mask to 0xFF and clears the in-service and request registers, special mask mode and the read selection. `int_out` stays low until configuration completes.
- R2: After the start word, the next `a0=1` write is the vector base, whose bits 7:3 are kept. A cascade word follows unless start-word bit 1 (single) is set. A mode word follows if start-word bit 0 is set. The block then enters `ST_RUN`, and each granted vector equals {base[7:3], level}.
- R3: In `ST_RUN`, an `a0=1` write loads the 8-bit mask, and an `a0=1` read returns it. A set mask bit keeps that level from raising `int_out`.
- R4: With start-word bit 3 clear (edge capture), a rising input sets its request bit. The bit holds after the input falls, until the level is acknowledged.
- R5: With start-word bit 3 set (level capture), each request bit follows its input one cycle later.
- R6: Priority is fixed: level 0 is highest and level 7 lowest. An acknowledge grants the lowest-numbered eligible level.
- R7: With special mask mode off, an in-service bit at level k blocks level k and every level above k. Levels below k still raise `int_out`.
- R8: Command 0x68 turns special mask mode on and 0x48 turns it off. While it is on, only the mask gates requests.
- R9: Commands of the form 0b0000_101s select what an `a0=0` read returns: s=0 returns the request register, s=1 the in-service register.
- R10: Command 0x60|L (L = bits 2:0) clears only in-service bit L. Other `a0=0` commands with bits 4 and 3 clear have no effect.
- R11: An acknowledge with a winner clears that level's request bit and sets its in-service bit. In the same cycle it drives the vector on `rd_data` with `vec_out_valid` high. An acknowledge with nothing eligible changes nothing and drives nothing.
- R12: A primary that grants a line whose bit is set in its cascade word (and single mode is off) drives `cas_out` = level with `cas_valid_out` high. It leaves `vec_out_valid` low.
- R13: A secondary (`is_master` low) answers an acknowledge only when `cas_valid_in` is high and `cas_in` equals bits 2:0 of its cascade word.
- R14: Before the first start word, `a0=1` writes are ignored (the mask reads 0xFF) and `int_out` stays low whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | 1 = primary role, 0 = secondary role |
| a0 | input | 1 | Register-port address bit |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, or vector during an answered acknowledge |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt output to processor or primary |
| ack | input | 1 | Acknowledge pulse |
| cas_in | input | 3 | Cascade line number from the primary |
| cas_valid_in | input | 1 | Primary is addressing a secondary |
| cas_out | output | 3 | Cascade line number driven by a primary |
| cas_valid_out | output | 1 | `cas_out` is valid |
| vec_out_valid | output | 1 | `rd_data` carries a vector this cycle |

## Verification
The main function is driven by a set of request patterns, each applied to the primary and the secondary at once. Patterns with a single line tell apart direct vectors from cascaded ones. Patterns with two lines on the same instance expose the priority order. Mixed patterns decide whether the cascade line outranks or yields to a primary line, and they show that a secondary stays silent when the primary keeps the grant. Separate sequences raise a lower level while a higher level is in service, once with special mask mode off and once with it on. They also reconfigure the primary for level capture and single mode, so that the request bits are seen both holding and following the input.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int N_LINES = 8;
    localparam int LVL_W   = $clog2(N_LINES);
    localparam int DATA_W  = 8;

    typedef enum logic [2:0] {
        ST_UNINIT,
        ST_GET_BASE,
        ST_GET_CASC,
        ST_GET_MODE,
        ST_RUN
    } seq_state_t;
endpackage

// File: rtl/pic_seq_fsm.sv
module pic_seq_fsm
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              a0,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ready,
    output logic              init_pulse,
    output logic              imr_load,
    output logic              cmd_ocw3,
    output logic              cmd_eoi,
    output logic              cfg_level,
    output logic              cfg_single,
    output logic [DATA_W-1:LVL_W] base_hi,
    output logic [DATA_W-1:0] casc_cfg
);
    seq_state_t state_q, state_d;
    logic       want_mode_q;
    logic       start_w, data_w, cmd_w;

    assign start_w = wr_en && !a0 && wr_data[4];
    assign data_w  = wr_en && a0;
    assign cmd_w   = wr_en && !a0 && !wr_data[4] && (state_q == ST_RUN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_UNINIT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start_w) begin
            state_d = ST_GET_BASE;
        end else if (data_w) begin
            unique case (state_q)
                ST_GET_BASE: state_d = cfg_single ? (want_mode_q ? ST_GET_MODE : ST_RUN)
                                                  : ST_GET_CASC;
                ST_GET_CASC: state_d = want_mode_q ? ST_GET_MODE : ST_RUN;
                ST_GET_MODE: state_d = ST_RUN;
                ST_UNINIT,
                ST_RUN:      state_d = state_q;
                default:     state_d = ST_UNINIT;
            endcase
        end
    end

    // outputs
    always_comb begin
        ready      = (state_q == ST_RUN);
        init_pulse = start_w;
        imr_load   = data_w && (state_q == ST_RUN);
        cmd_ocw3   = cmd_w && wr_data[3] && !wr_data[7];
        cmd_eoi    = cmd_w && !wr_data[3] && (wr_data[7:5] == 3'b011);
    end

    // configuration words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            want_mode_q <= 1'b0;
            cfg_single  <= 1'b0;
            cfg_level   <= 1'b0;
            base_hi     <= '0;
            casc_cfg    <= '0;
        end else if (start_w) begin
            want_mode_q <= wr_data[0];
            cfg_single  <= wr_data[1];
            cfg_level   <= wr_data[3];
            casc_cfg    <= '0;
        end else if (data_w && state_q == ST_GET_BASE) begin
            base_hi     <= wr_data[DATA_W-1:LVL_W];
        end else if (data_w && state_q == ST_GET_CASC) begin
            casc_cfg    <= wr_data;
        end
    end
endmodule

// File: rtl/pic_req_capture.sv
module pic_req_capture
    import pic_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines,
    input  logic               level_mode,
    input  logic               clr_all,
    input  logic [N_LINES-1:0] ack_clr,
    output logic [N_LINES-1:0] irr
);
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic prev_q, irr_q, irr_d;
        always_comb begin
            if (level_mode) irr_d = lines[g];
            else            irr_d = irr_q | (lines[g] & ~prev_q);
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                irr_q  <= 1'b0;
            end else begin
                prev_q <= lines[g];
                irr_q  <= clr_all ? 1'b0 : (irr_d & ~ack_clr[g]);
            end
        end
        assign irr[g] = irr_q;
    end
endmodule

// File: rtl/pic_prio.sv
module pic_prio
    import pic_pkg::*;
(
    input  logic [N_LINES-1:0] irr,
    input  logic [N_LINES-1:0] imr,
    input  logic [N_LINES-1:0] isr,
    input  logic               smm,
    output logic               any,
    output logic [LVL_W-1:0]   lvl
);
    logic [N_LINES-1:0] elig;
    always_comb begin
        logic blk;
        blk = 1'b0;
        for (int i = 0; i < N_LINES; i++) begin
            blk     = blk | isr[i];
            elig[i] = irr[i] & ~imr[i] & (smm | ~blk);
        end
        lvl = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (elig[i]) lvl = i[LVL_W-1:0];
        end
        any = |elig;
    end
endmodule

// File: rtl/pic8_cascade.sv
module pic8_cascade
    import pic_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               is_master,
    input  logic               a0,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [N_LINES-1:0] irq_in,
    output logic               int_out,
    input  logic               ack,
    input  logic [LVL_W-1:0]   cas_in,
    input  logic               cas_valid_in,
    output logic [LVL_W-1:0]   cas_out,
    output logic               cas_valid_out,
    output logic               vec_out_valid
);
    logic                      seq_ready, init_pulse, imr_load, cmd_ocw3, cmd_eoi;
    logic                      cfg_level, cfg_single;
    logic [DATA_W-1:LVL_W]     base_hi;
    logic [DATA_W-1:0]         casc_cfg;
    logic [N_LINES-1:0]        irr_q, isr_q, imr_q, grant_set, eoi_clr;
    logic                      smm_q, rd_isr_q;
    logic                      win_any, grant, to_slave, addressed;
    logic [LVL_W-1:0]          grant_lvl;

    pic_seq_fsm u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .a0(a0), .wr_data(wr_data),
        .ready(seq_ready), .init_pulse(init_pulse), .imr_load(imr_load),
        .cmd_ocw3(cmd_ocw3), .cmd_eoi(cmd_eoi), .cfg_level(cfg_level),
        .cfg_single(cfg_single), .base_hi(base_hi), .casc_cfg(casc_cfg)
    );

    pic_req_capture u_cap (
        .clk(clk), .rst_n(rst_n), .lines(irq_in), .level_mode(cfg_level),
        .clr_all(init_pulse), .ack_clr(grant_set), .irr(irr_q)
    );

    pic_prio u_prio (
        .irr(irr_q), .imr(imr_q), .isr(isr_q), .smm(smm_q),
        .any(win_any), .lvl(grant_lvl)
    );

    assign addressed = is_master || (cas_valid_in && cas_in == casc_cfg[LVL_W-1:0]);
    assign grant     = ack && seq_ready && win_any && addressed;
    assign to_slave  = is_master && !cfg_single && casc_cfg[grant_lvl];
    assign grant_set = grant ? (N_LINES'(1) << grant_lvl) : '0;
    assign eoi_clr   = cmd_eoi ? (N_LINES'(1) << wr_data[LVL_W-1:0]) : '0;

    assign int_out       = seq_ready && win_any;
    assign cas_valid_out = grant && to_slave;
    assign cas_out       = cas_valid_out ? grant_lvl : '0;
    assign vec_out_valid = grant && !to_slave;

    always_comb begin
        if (vec_out_valid)  rd_data = {base_hi, grant_lvl};
        else if (!rd_en)    rd_data = '0;
        else if (a0)        rd_data = imr_q;
        else if (rd_isr_q)  rd_data = isr_q;
        else                rd_data = irr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imr_q    <= '1;
            isr_q    <= '0;
            smm_q    <= 1'b0;
            rd_isr_q <= 1'b0;
        end else if (init_pulse) begin
            imr_q    <= '1;
            isr_q    <= '0;
            smm_q    <= 1'b0;
            rd_isr_q <= 1'b0;
        end else begin
            isr_q <= (isr_q | grant_set) & ~eoi_clr;
            if (imr_load) imr_q <= wr_data;
            if (cmd_ocw3 && wr_data[6]) smm_q    <= wr_data[5];
            if (cmd_ocw3 && wr_data[1]) rd_isr_q <= wr_data[0];
        end
    end
endmodule

// File: rtl/pic8_cascade_chk.sv
module pic8_cascade_chk
    import pic_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               ready,
    input logic               int_out,
    input logic               init_pulse,
    input logic               eoi,
    input logic [LVL_W-1:0]   eoi_lvl,
    input logic               grant,
    input logic [LVL_W-1:0]   grant_lvl,
    input logic [N_LINES-1:0] irr_q,
    input logic [N_LINES-1:0] isr_q,
    input logic [N_LINES-1:0] imr_q,
    input logic               smm_q,
    input logic               vec_out_valid,
    input logic               cas_valid_out
);
    p_quiet_until_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !int_out);

    p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> (imr_q == 8'hFF && isr_q == '0 && irr_q == '0));

    p_masked_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((irr_q & ~imr_q) == '0) |-> !int_out);

    p_smm_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && smm_q && (irr_q & ~imr_q) != '0) |-> int_out);

    p_eoi_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !grant) |=> !isr_q[$past(eoi_lvl)]);

    p_grant_sets_isr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !eoi && !init_pulse) |=> isr_q[$past(grant_lvl)]);

    p_one_answer_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_out_valid && cas_valid_out));
endmodule

bind pic8_cascade pic8_cascade_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ready(seq_ready), .int_out(int_out),
    .init_pulse(init_pulse), .eoi(cmd_eoi), .eoi_lvl(wr_data[2:0]),
    .grant(grant), .grant_lvl(grant_lvl), .irr_q(irr_q), .isr_q(isr_q),
    .imr_q(imr_q), .smm_q(smm_q), .vec_out_valid(vec_out_valid),
    .cas_valid_out(cas_valid_out)
);

// File: tb/pic8_cascade_test.sv
`timescale 1ns/1ps
module pic8_cascade_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a0 = 1'b0, ack = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       m_wr = 1'b0, m_rd = 1'b0, s_wr = 1'b0, s_rd = 1'b0;
    logic [7:0] m_lines = 8'h00, s_lines = 8'h00;
    logic [7:0] m_rdata, s_rdata;
    logic       m_int, s_int, m_cv, s_cv, m_vv, s_vv;
    logic [2:0] m_cas, s_cas;
    int         checks = 0, failures = 0;

    always #10 clk = ~clk;

    pic8_cascade uut (
        .clk(clk), .rst_n(rst_n), .is_master(1'b1), .a0(a0), .wr_en(m_wr),
        .rd_en(m_rd), .wr_data(wdata), .rd_data(m_rdata),
        .irq_in({m_lines[7:3], s_int, m_lines[1:0]}), .int_out(m_int),
        .ack(ack), .cas_in(3'd0), .cas_valid_in(1'b0), .cas_out(m_cas),
        .cas_valid_out(m_cv), .vec_out_valid(m_vv)
    );

    pic8_cascade u_slave (
        .clk(clk), .rst_n(rst_n), .is_master(1'b0), .a0(a0), .wr_en(s_wr),
        .rd_en(s_rd), .wr_data(wdata), .rd_data(s_rdata), .irq_in(s_lines),
        .int_out(s_int), .ack(ack), .cas_in(m_cas), .cas_valid_in(m_cv),
        .cas_out(s_cas), .cas_valid_out(s_cv), .vec_out_valid(s_vv)
    );

    // {master lines, slave lines, expected vector, answered by slave}
    localparam logic [24:0] TBL [7] = '{
        {8'h20, 8'h00, 8'h05, 1'b0},
        {8'h22, 8'h00, 8'h01, 1'b0},
        {8'h00, 8'h08, 8'h0B, 1'b1},
        {8'h20, 8'h01, 8'h08, 1'b1},
        {8'h01, 8'h80, 8'h00, 1'b0},
        {8'h80, 8'h40, 8'h0E, 1'b1},
        {8'h18, 8'h00, 8'h03, 1'b0}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit sl, input bit a, input logic [7:0] d);
        @(negedge clk);
        a0 = a; wdata = d;
        if (sl) s_wr = 1'b1; else m_wr = 1'b1;
        @(negedge clk);
        m_wr = 1'b0; s_wr = 1'b0; a0 = 1'b0;
    endtask

    task automatic rd(input bit sl, input bit a, output logic [7:0] d);
        @(negedge clk);
        a0 = a;
        if (sl) s_rd = 1'b1; else m_rd = 1'b1;
        #2;
        d = sl ? s_rdata : m_rdata;
        m_rd = 1'b0; s_rd = 1'b0; a0 = 1'b0;
    endtask

    task automatic do_ack(output logic [7:0] vec, output logic mv, output logic sv,
                          output logic cv, output logic [2:0] cas);
        @(negedge clk);
        ack = 1'b1;
        #2;
        mv = m_vv; sv = s_vv; cv = m_cv; cas = m_cas;
        vec = m_vv ? m_rdata : s_rdata;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic drain();
        logic [7:0] v; logic mv, sv, cv; logic [2:0] c;
        for (int k = 0; k < 20; k++) begin
            settle();
            if (!m_int) break;
            do_ack(v, mv, sv, cv, c);
            if (sv) begin
                wr(1'b1, 1'b0, 8'h60 | {5'd0, v[2:0]});
                wr(1'b0, 1'b0, 8'h62);
            end else begin
                wr(1'b0, 1'b0, 8'h60 | {5'd0, v[2:0]});
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] d, v;
        logic mv, sv, cv;
        logic [2:0] c;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 int low after reset", {7'd0, m_int}, 8'h00);

        // R14: writes before configuration are ignored
        wr(1'b0, 1'b1, 8'h00);
        rd(1'b0, 1'b1, d);
        check("R14 mask untouched before start", d, 8'hFF);
        m_lines = 8'h01;
        settle();
        check("R14 int low before start", {7'd0, m_int}, 8'h00);
        m_lines = 8'h00;
        settle();

        // configuration of both instances
        wr(1'b0, 1'b0, 8'h11); wr(1'b0, 1'b1, 8'h00);
        wr(1'b0, 1'b1, 8'h04); wr(1'b0, 1'b1, 8'h01);
        wr(1'b0, 1'b0, 8'h68); wr(1'b0, 1'b0, 8'h0A);
        wr(1'b1, 1'b0, 8'h11); wr(1'b1, 1'b1, 8'h08);
        wr(1'b1, 1'b1, 8'h02); wr(1'b1, 1'b1, 8'h01);
        wr(1'b1, 1'b0, 8'h68); wr(1'b1, 1'b0, 8'h0A);
        rd(1'b0, 1'b1, d);
        check("R1 mask all set after start", d, 8'hFF);
        wr(1'b0, 1'b1, 8'h5A);
        rd(1'b0, 1'b1, d);
        check("R2 R3 mask write after four words", d, 8'h5A);
        wr(1'b0, 1'b1, 8'h00);
        wr(1'b1, 1'b1, 8'h00);

        // R11: acknowledge with nothing pending
        do_ack(v, mv, sv, cv, c);
        check("R11 empty ack no answer", {5'd0, mv, sv, cv}, 8'h00);

        // R3 / R4: mask gating and edge hold
        wr(1'b0, 1'b1, 8'h01);
        m_lines = 8'h01;
        settle();
        check("R3 masked level keeps int low", {7'd0, m_int}, 8'h00);
        m_lines = 8'h00;
        settle();
        rd(1'b0, 1'b0, d);
        check("R4 edge request held after input falls", d, 8'h01);
        wr(1'b0, 1'b1, 8'h00);
        settle();
        check("R3 unmask raises int", {7'd0, m_int}, 8'h01);
        do_ack(v, mv, sv, cv, c);
        check("R11 vector for level 0", v, 8'h00);
        check("R11 vector valid flag", {7'd0, mv}, 8'h01);
        wr(1'b0, 1'b0, 8'h0B);
        rd(1'b0, 1'b0, d);
        check("R9 R11 in-service after ack", d, 8'h01);
        wr(1'b0, 1'b0, 8'h0A);
        rd(1'b0, 1'b0, d);
        check("R9 R11 request cleared by ack", d, 8'h00);
        wr(1'b0, 1'b0, 8'h20);
        wr(1'b0, 1'b0, 8'h0B);
        rd(1'b0, 1'b0, d);
        check("R10 non-specific command ignored", d, 8'h01);
        wr(1'b0, 1'b0, 8'h60);
        rd(1'b0, 1'b0, d);
        check("R10 specific clear level 0", d, 8'h00);
        wr(1'b0, 1'b0, 8'h0A);

        // table of patterns: R6 priority, R12 cascade, R13 identity
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            m_lines = TBL[i][24:17];
            s_lines = TBL[i][16:9];
            settle();
            do_ack(v, mv, sv, cv, c);
            check($sformatf("R6 vector entry %0d", i), v, TBL[i][8:1]);
            if (TBL[i][0]) begin
                check($sformatf("R12 cascade flags entry %0d", i),
                      {mv, cv, 3'd0, c}, {1'b0, 1'b1, 6'd2});
                check($sformatf("R13 addressed secondary answers %0d", i),
                      {7'd0, sv}, 8'h01);
            end else begin
                check($sformatf("R13 secondary silent entry %0d", i),
                      {5'd0, mv, sv, cv}, 8'h04);
            end
            @(negedge clk);
            m_lines = 8'h00; s_lines = 8'h00;
            if (sv) begin
                wr(1'b1, 1'b0, 8'h60 | {5'd0, v[2:0]});
                wr(1'b0, 1'b0, 8'h62);
            end else begin
                wr(1'b0, 1'b0, 8'h60 | {5'd0, v[2:0]});
            end
            drain();
        end

        // R7: normal nesting
        wr(1'b0, 1'b0, 8'h48);
        @(negedge clk); m_lines = 8'h10;
        settle();
        do_ack(v, mv, sv, cv, c);
        check("R7 level 4 granted", v, 8'h04);
        @(negedge clk); m_lines = 8'h40;
        settle();
        check("R7 level 6 blocked by level 4", {7'd0, m_int}, 8'h00);
        @(negedge clk); m_lines = 8'h42;
        settle();
        check("R7 level 1 passes level 4", {7'd0, m_int}, 8'h01);
        do_ack(v, mv, sv, cv, c);
        check("R7 nested vector 1", v, 8'h01);
        wr(1'b0, 1'b0, 8'h61);
        wr(1'b0, 1'b0, 8'h64);
        settle();
        do_ack(v, mv, sv, cv, c);
        check("R7 level 6 after clears", v, 8'h06);
        wr(1'b0, 1'b0, 8'h66);
        @(negedge clk); m_lines = 8'h00;

        // R8: special mask mode
        wr(1'b0, 1'b0, 8'h68);
        @(negedge clk); m_lines = 8'h08;
        settle();
        do_ack(v, mv, sv, cv, c);
        check("R8 level 3 granted", v, 8'h03);
        @(negedge clk); m_lines = 8'h88;
        settle();
        check("R8 level 7 passes level 3", {7'd0, m_int}, 8'h01);
        do_ack(v, mv, sv, cv, c);
        check("R8 vector 7 under special mask", v, 8'h07);
        wr(1'b0, 1'b0, 8'h0B);
        rd(1'b0, 1'b0, d);
        check("R9 in-service shows 3 and 7", d, 8'h88);
        wr(1'b0, 1'b0, 8'h63);
        rd(1'b0, 1'b0, d);
        check("R10 only level 3 cleared", d, 8'h80);
        wr(1'b0, 1'b0, 8'h67);
        rd(1'b0, 1'b0, d);
        check("R10 level 7 cleared", d, 8'h00);
        wr(1'b0, 1'b0, 8'h0A);
        @(negedge clk); m_lines = 8'h00;
        settle();

        // R5 / R2: level capture, single mode, three words, new base
        wr(1'b0, 1'b0, 8'h1B); wr(1'b0, 1'b1, 8'h20); wr(1'b0, 1'b1, 8'h01);
        wr(1'b0, 1'b1, 8'h00);
        rd(1'b0, 1'b1, d);
        check("R2 three-word sequence reaches run", d, 8'h00);
        @(negedge clk); m_lines = 8'h40;
        settle();
        rd(1'b0, 1'b0, d);
        check("R5 request follows high input", d, 8'h40);
        @(negedge clk); m_lines = 8'h00;
        settle();
        rd(1'b0, 1'b0, d);
        check("R5 request follows low input", d, 8'h00);
        @(negedge clk); m_lines = 8'h40;
        settle();
        do_ack(v, mv, sv, cv, c);
        check("R2 vector from new base", v, 8'h26);
        check("R12 single mode never cascades", {7'd0, cv}, 8'h00);
        @(negedge clk); m_lines = 8'h00;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule